// File: doc/BRIEF.md
# SYSREF Pulse Generator

This block produces the reference pulse train used to line up several data converters on a common clock edge. It runs on the divided device clock, so each pulse edge falls on a clock edge. A pulse is high for a programmed number of clock cycles and then low for the same number. The train can be one pulse, a programmed burst of pulses, or an open-ended stream.

A train starts on a rising edge of an external request pin, after that pin passes through a two-flop synchronizer. A train can also start on a rising edge of a software start bit that is already synchronous to the clock. The mode, burst length and half-period are captured when the trigger is accepted. A busy flag covers the whole train. Triggers that arrive while it is set are dropped.

Top module: `sysref_pulse_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no trigger, `pulse_out` and `busy` are both 0.
- R2: With `mode_sel` = 0 or 3 (single), one accepted trigger gives exactly one pulse: `pulse_out` is high for H cycles and then low for H cycles, after which the block is idle.
- R3: With `mode_sel` = 1 (burst), one accepted trigger gives `pulse_count` back-to-back pulses, each of period 2H, and then the block stops. A count of 0 gives one pulse.
- R4: With `mode_sel` = 2 (continuous), periods repeat while the run level is high. The run level is the synchronized request OR `sw_start`. The run level is examined only at the end of each full period, so the train stops after a complete low half and never cuts a pulse short.
- R5: On a request trigger, `pulse_out` first reads high after the third rising clock edge that samples `req_in` high. A request held high starts only one train.
- R6: On a software trigger, `pulse_out` first reads high after the same clock edge that first samples `sw_start` high.
- R7: The half-period H equals `period_div` in clock cycles, and a value of 0 is treated as 1.
- R8: `busy` rises with the first pulse and falls right after the last low half. A trigger that arrives while `busy` is high has no effect.
- R9: The mode, count and half-period are taken at the trigger. Changing those inputs while `busy` is high does not alter the running train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0/3 single, 1 burst, 2 continuous |
| pulse_count | input | CNT_W | Pulses per burst in mode 1 |
| period_div | input | DIV_W | Half-period H in clock cycles |
| req_in | input | 1 | Asynchronous start request |
| sw_start | input | 1 | Synchronous software start bit |
| pulse_out | output | 1 | Reference pulse train |
| busy | output | 1 | High while a train is in progress |

## Verification
The hardest case to reach is the stop decision in continuous mode. It depends on where the request falls, after the synchronizer delay, relative to the end of a period. The bench drops the request exactly 2H·m cycles after raising it, which lands on a period boundary, and also one cycle later, so that both sides of the boundary are tested. A second hard case is a request edge that arrives during a running software-started burst while the configuration inputs are also changing. The bench then checks that the burst keeps its captured shape and that the request, still held high, does not start a new train.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'd0,
    MODE_NSHOT      = 2'd1,
    MODE_CONT       = 2'd2,
    MODE_SINGLE_ALT = 2'd3
  } sysref_mode_e;
endpackage

// File: rtl/sysref_trig_front.sv
module sysref_trig_front (
  input  logic clk,
  input  logic rst_ni,
  input  logic req_in,
  input  logic sw_start,
  output logic trig,
  output logic run_lvl
);
  logic req_s1_q, req_s2_q, req_s3_q, sw_q;
  logic req_s1_d, req_s2_d, req_s3_d, sw_d;

  always_comb begin
    req_s1_d = req_in;
    req_s2_d = req_s1_q;
    req_s3_d = req_s2_q;
    sw_d     = sw_start;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      req_s3_q <= 1'b0;
      sw_q     <= 1'b0;
    end else begin
      req_s1_q <= req_s1_d;
      req_s2_q <= req_s2_d;
      req_s3_q <= req_s3_d;
      sw_q     <= sw_d;
    end
  end

  assign trig    = (req_s2_q & ~req_s3_q) | (sw_start & ~sw_q);
  assign run_lvl = req_s2_q | sw_start;

  // R5
  req_edge_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_s2_q && !req_s3_q) |-> $past(req_in, 2));
endmodule

// File: rtl/sysref_phase_timer.sv
module sysref_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             restart_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             period_end_o,
  output logic             hi_o
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hi_q, hi_d;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] per_last;
  logic          cnt_en;

  assign cnt_inc  = cnt_q + CW'(1);
  assign per_last = {half_i, 1'b0} - CW'(1);
  assign cnt_en   = start_i | restart_i | stop_i | act_q;

  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    act_d = act_q;
    if (start_i || restart_i) begin
      cnt_d = '0;
      hi_d  = 1'b1;
      act_d = 1'b1;
    end else if (stop_i) begin
      cnt_d = '0;
      hi_d  = 1'b0;
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_inc;
      hi_d  = (cnt_inc < {1'b0, half_i});
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      act_q <= act_d;
    end
  end

  assign period_end_o = act_q && (cnt_q == per_last);
  assign hi_o         = hi_q;

  // R7
  hi_within_half_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hi_q && act_q) |-> (cnt_q < {1'b0, half_i}));
  // R2
  end_is_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    period_end_o |-> !hi_q);
endmodule

// File: rtl/sysref_burst_ctrl.sv
module sysref_burst_ctrl
  import sysref_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             run_lvl_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             period_end_i,
  input  logic             pulse_i,
  output logic             start_o,
  output logic             restart_o,
  output logic             stop_o,
  output logic [DIV_W-1:0] half_o,
  output logic             busy_o
);
  localparam int RW = CNT_W + 1;

  sysref_mode_e     mode_q, mode_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic             accept, last, cfg_en;
  logic [CNT_W-1:0] cnt_eff;

  assign cnt_eff = (count_i == '0) ? CNT_W'(1) : count_i;
  assign accept  = trig_i & ~busy_q;

  always_comb begin
    case (mode_q)
      MODE_NSHOT: last = (left_q <= CNT_W'(1));
      MODE_CONT:  last = ~run_lvl_i;
      default:    last = 1'b1;
    endcase
  end

  assign start_o   = accept;
  assign restart_o = busy_q & period_end_i & ~last;
  assign stop_o    = busy_q & period_end_i & last;
  assign cfg_en    = accept | restart_o | stop_o;

  always_comb begin
    mode_d  = mode_q;
    busy_d  = busy_q;
    left_d  = left_q;
    total_d = total_q;
    half_d  = half_q;
    if (accept) begin
      mode_d  = sysref_mode_e'(mode_i);
      busy_d  = 1'b1;
      left_d  = cnt_eff;
      total_d = cnt_eff;
      half_d  = (div_i == '0) ? DIV_W'(1) : div_i;
    end else if (restart_o) begin
      if (mode_q == MODE_NSHOT) left_d = left_q - CNT_W'(1);
    end else if (stop_o) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SINGLE;
      busy_q  <= 1'b0;
      left_q  <= '0;
      total_q <= '0;
      half_q  <= DIV_W'(1);
    end else if (cfg_en) begin
      mode_q  <= mode_d;
      busy_q  <= busy_d;
      left_q  <= left_d;
      total_q <= total_d;
      half_q  <= half_d;
    end
  end

  assign half_o = half_q;
  assign busy_o = busy_q;

  // Checker state: rising edges of the pulse seen within one train
  logic          pulse_q;
  logic [RW-1:0] rise_cnt_q;
  logic          pulse_rise;
  assign pulse_rise = pulse_i & ~pulse_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q    <= 1'b0;
      rise_cnt_q <= '0;
    end else begin
      pulse_q <= pulse_i;
      if (accept) rise_cnt_q <= '0;
      else if (pulse_rise && (rise_cnt_q != '1)) rise_cnt_q <= rise_cnt_q + RW'(1);
    end
  end

  // R8
  busy_from_trig_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(trig_i));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_q |-> !pulse_i);
  // R4
  no_runt_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy_q) |-> !$past(pulse_i));
  // R2
  single_once_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && (mode_q == MODE_SINGLE || mode_q == MODE_SINGLE_ALT)) |-> (rise_cnt_q <= RW'(1)));
  // R3
  nshot_limit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && mode_q == MODE_NSHOT) |-> (rise_cnt_q <= {1'b0, total_q}));
endmodule

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] pulse_count,
  input  logic [DIV_W-1:0] period_div,
  input  logic             req_in,
  input  logic             sw_start,
  output logic             pulse_out,
  output logic             busy
);
  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic             trig, run_lvl;
  logic             start, restart, stop, period_end, hi;
  logic [DIV_W-1:0] half;

  sysref_trig_front u_front (
    .clk      (clk),
    .rst_ni   (rst_s2_q),
    .req_in   (req_in),
    .sw_start (sw_start),
    .trig     (trig),
    .run_lvl  (run_lvl)
  );

  sysref_burst_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_s2_q),
    .trig_i       (trig),
    .run_lvl_i    (run_lvl),
    .mode_i       (mode_sel),
    .count_i      (pulse_count),
    .div_i        (period_div),
    .period_end_i (period_end),
    .pulse_i      (hi),
    .start_o      (start),
    .restart_o    (restart),
    .stop_o       (stop),
    .half_o       (half),
    .busy_o       (busy)
  );

  sysref_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk          (clk),
    .rst_ni       (rst_s2_q),
    .start_i      (start),
    .restart_i    (restart),
    .stop_i       (stop),
    .half_i       (half),
    .period_end_o (period_end),
    .hi_o         (hi)
  );

  assign pulse_out = hi;
endmodule

// File: tb/sysref_pulse_gen_bench.sv
module sysref_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DIV_W = 8;

  logic             clk;
  logic             rst_n;
  logic [1:0]       mode_sel;
  logic [CNT_W-1:0] pulse_count;
  logic [DIV_W-1:0] period_div;
  logic             req_in, sw_start;
  logic             pulse_out, busy;

  sysref_pulse_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_sysref_pulse_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pulse_count(pulse_count),
    .period_div(period_div), .req_in(req_in), .sw_start(sw_start),
    .pulse_out(pulse_out), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit    p;
    bit    b;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  task automatic push_item(bit p, bit b, string tag);
    exp_t e;
    e.p = p; e.b = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Expected train: lat idle cycles, n periods of half h, then idle tail
  task automatic push_train(int lat, int h, int n, int tail, string tag);
    for (int i = 0; i < lat; i++) push_item(1'b0, 1'b0, tag);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < h; i++) push_item(1'b1, 1'b1, tag);
      for (int i = 0; i < h; i++) push_item(1'b0, 1'b1, tag);
    end
    for (int i = 0; i < tail; i++) push_item(1'b0, 1'b0, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, pulse_out, e.p, "pulse_out");
      check(e.tag, busy, e.b, "busy");
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'd0; pulse_count = '0; period_div = 8'd1;
    req_in = 1'b0; sw_start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", pulse_out, 1'b0, "pulse_out in reset");
    check("R1", busy, 1'b0, "busy in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push_train(0, 1, 0, 3, "R1");
    drain();

    // R2 R6: single via software, H=3
    mode_sel = 2'd0; period_div = 8'd3; sw_start = 1'b1;
    push_train(0, 3, 1, 3, "R2_R6");
    @(negedge clk); sw_start = 1'b0;
    drain();

    // R3 R5: burst of 4 via request, H=2, level held afterwards
    mode_sel = 2'd1; pulse_count = 8'd4; period_div = 8'd2; req_in = 1'b1;
    push_train(2, 2, 4, 10, "R3_R5");
    drain();
    req_in = 1'b0;
    repeat (4) @(negedge clk);

    // R3 R7: count 0 -> one pulse, div 0 -> H=1
    mode_sel = 2'd1; pulse_count = 8'd0; period_div = 8'd0; sw_start = 1'b1;
    push_train(0, 1, 1, 3, "R3_R7");
    @(negedge clk); sw_start = 1'b0;
    drain();

    // R8 R9: burst of 3, H=2; reconfigure and request while busy
    mode_sel = 2'd1; pulse_count = 8'd3; period_div = 8'd2; sw_start = 1'b1;
    push_train(0, 2, 3, 8, "R8_R9");
    @(negedge clk); sw_start = 1'b0;
    mode_sel = 2'd2; pulse_count = 8'd1; period_div = 8'd5;
    repeat (2) @(negedge clk); req_in = 1'b1;
    drain();
    req_in = 1'b0;
    repeat (4) @(negedge clk);

    // R4: continuous, H=2, request held 9 cycles -> 3 periods
    mode_sel = 2'd2; period_div = 8'd2; req_in = 1'b1;
    push_train(2, 2, 3, 4, "R4");
    repeat (9) @(negedge clk); req_in = 1'b0;
    drain();

    // R4: held exactly 8 cycles -> 2 periods (boundary)
    req_in = 1'b1;
    push_train(2, 2, 2, 4, "R4");
    repeat (8) @(negedge clk); req_in = 1'b0;
    drain();

    // R2 R5: mode 3 single via request, H=4
    mode_sel = 2'd3; period_div = 8'd4; req_in = 1'b1;
    push_train(2, 4, 1, 4, "R2_R5");
    drain();
    req_in = 1'b0;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule